// File: doc/BRIEF.md
# Short-Backward-Branch Loop Fetch Controller

This block sits beside an instruction fetch path and decides, one fetch at a time, whether the next instruction is read from main instruction memory or from a small loop buffer. It does not need tags or valid bits. Instead, it spots a short backward branch in the decode stream: a branch whose displacement has all upper bits set. The low displacement bits of that branch give the loop length. The block then follows execution through the loop with a counter, so it knows ahead of time whether the next fetch will hit.

The first taken short backward branch starts a fill pass. During that pass, fetches still come from main memory and each one is also written into the buffer. When the same branch is taken again, the controller switches the fetch source to the buffer. It keeps that source for as long as the loop runs straight through and keeps branching back. Any other change of flow returns the controller to idle, as does the loop falling through its closing branch. The buffer array and the data multiplexer sit outside this block. They are driven by the two outputs, `fillEn` and `useBuffer`.

The pipeline is taken to be one deep between decode and execute. The first execute event after a short backward branch is decoded belongs to that branch.

Top module: `loop_fetch_ctrl`

## Requirements
- R1: After reset, and while reset is held, the controller is idle and both `fillEn` and `useBuffer` are low.
- R2: A decoded word is a short backward branch only in this case: `decValid` is high, the opcode `decWord[15:12]` is 4'hD (conditional branch) or 4'hE (unconditional branch), and `decWord[11:3]` are all ones. Any other word, including a branch with a short upper field, never starts a fill.
- R3: In idle, when a short backward branch has been decoded and the next execute event is `exTaken`, the controller enters the fill pass. `fillEn` goes high in that same cycle, and `useBuffer` stays low throughout the fill pass.
- R4: If the first execute event after such a decode is `exSeq` or `exCof`, the candidate is dropped, and a later `exTaken` with no new decode starts nothing.
- R5: On a taken trigger, the counter is loaded with the value whose low bits are `decWord[2:0]` of the trigger and whose top bit is one. It increments on every `exSeq`, so it reaches zero after exactly 8 minus `decWord[2:0]` sequential instructions. A low field of zero means 8.
- R6: When the counter is zero, during the fill pass or the active phase, any change of flow (`exTaken` or `exCof`) is credited to the trigger. `useBuffer` goes high in that same cycle, and the counter is reloaded with the trigger's displacement.
- R7: When the counter is zero, an `exSeq` means the trigger fell through. Both outputs drop in that cycle and the controller returns to idle.
- R8: When the counter is non-zero, a change of flow during the fill pass or the active phase drops both outputs in that cycle and returns the controller to idle.
- R9: The active phase never leads to the fill pass. A short backward branch decoded outside idle is ignored, and the trigger's displacement is kept.
- R10: `fillEn` and `useBuffer` are never high together. Both outputs follow, in the same cycle, the state that the current events lead to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | A valid instruction word is in decode |
| decWord | input | 16 | Decoded instruction word: opcode and displacement |
| exSeq | input | 1 | Execute completed an instruction that did not change flow |
| exTaken | input | 1 | Execute completed a branch that was taken |
| exCof | input | 1 | Execute completed some other change of flow |
| fillEn | output | 1 | Write the current fetch into the loop buffer |
| useBuffer | output | 1 | Serve the current fetch from the loop buffer |

## Verification
The vector table runs a two-instruction loop through fill, two buffered passes and a fall-through exit. A separate eight-instruction loop, closed by an unconditional branch, checks the longest count and the case where a non-branch change of flow is credited at zero. The remaining patterns each isolate one condition:
- a foreign change of flow during the fill pass;
- a taken branch with no candidate;
- a branch whose upper field is not all ones;
- a candidate that is not taken.

A one-instruction loop then decodes a second short branch with a different length while it is active. If that second branch's length were taken up, the reload count would change and the loop would drop out one iteration early. Reset is also applied in the middle of an active loop.

// File: rtl/loopc_pkg.sv
package loopc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_ACTIVE = 2'd2
  } lcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic dispCapture; // latch low displacement of a candidate
    logic cntLoad;     // load counter from latched displacement
    logic cntInc;      // advance counter by one
  } lcStrobe_t;
endpackage

// File: rtl/lc_datapath.sv
module lc_datapath
  import loopc_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int DISP_W = 12,
  parameter int LOW_W  = 3,
  parameter logic [OPC_W-1:0] COND_OPC   = 4'hD,
  parameter logic [OPC_W-1:0] UNCOND_OPC = 4'hE,
  localparam int INSTR_W = OPC_W + DISP_W,
  localparam int CNT_W   = LOW_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               decValid,
  input  logic [INSTR_W-1:0] decWord,
  input  lcStrobe_t          strobe,
  output logic               sbbSeen,
  output logic               cntZero
);
  logic [OPC_W-1:0]        opcode;
  logic [DISP_W-LOW_W-1:0] upperDisp;
  logic [LOW_W-1:0]        lowDisp;
  logic [LOW_W-1:0]        trigDisp;
  logic [CNT_W-1:0]        cnt;
  logic                    isBranch;

  assign opcode    = decWord[INSTR_W-1 -: OPC_W];
  assign upperDisp = decWord[DISP_W-1:LOW_W];
  assign lowDisp   = decWord[LOW_W-1:0];
  assign isBranch  = (opcode == COND_OPC) || (opcode == UNCOND_OPC);
  assign sbbSeen   = decValid && isBranch && (&upperDisp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigDisp <= '0;
    end else if (strobe.dispCapture) begin
      trigDisp <= lowDisp;
    end
  end

  // negative count: top bit set, reaches zero after the loop length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntLoad) begin
      cnt <= {1'b1, trigDisp};
    end else if (strobe.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/lc_control.sv
module lc_control
  import loopc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sbbSeen,
  input  logic      cntZero,
  input  logic      exSeq,
  input  logic      exTaken,
  input  logic      exCof,
  output lcStrobe_t strobe,
  output logic      fillEn,
  output logic      useBuffer
);
  lcState_t state, nextState;
  logic     armed, armedNext;
  logic     flowChange, exEvent;

  assign flowChange = exTaken || exCof;
  assign exEvent    = flowChange || exSeq;

  always_comb begin
    nextState     = state;
    strobe.cntLoad = 1'b0;
    strobe.cntInc  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (armed && exTaken) begin
          nextState      = ST_FILL;
          strobe.cntLoad = 1'b1;
        end
      end
      ST_FILL, ST_ACTIVE: begin
        if (cntZero) begin
          if (flowChange) begin
            nextState      = ST_ACTIVE;
            strobe.cntLoad = 1'b1;
          end else if (exSeq) begin
            nextState = ST_IDLE;
          end
        end else begin
          if (flowChange) begin
            nextState = ST_IDLE;
          end else if (exSeq) begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // a candidate is held only while idle and not yet resolved
  always_comb begin
    strobe.dispCapture = (state == ST_IDLE) && (nextState == ST_IDLE) && sbbSeen;
    armedNext = (nextState == ST_IDLE) &&
                (strobe.dispCapture || (armed && !exEvent));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= nextState;
      armed <= armedNext;
    end
  end

  assign fillEn    = (nextState == ST_FILL);
  assign useBuffer = (nextState == ST_ACTIVE);
endmodule

// File: rtl/loop_fetch_ctrl.sv
module loop_fetch_ctrl
  import loopc_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int DISP_W = 12,
  parameter int LOW_W  = 3,
  parameter logic [OPC_W-1:0] COND_OPC   = 4'hD,
  parameter logic [OPC_W-1:0] UNCOND_OPC = 4'hE,
  localparam int INSTR_W = OPC_W + DISP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               decValid,
  input  logic [INSTR_W-1:0] decWord,
  input  logic               exSeq,
  input  logic               exTaken,
  input  logic               exCof,
  output logic               fillEn,
  output logic               useBuffer
);
  lcStrobe_t strobe;
  logic      sbbSeen;
  logic      cntZero;

  lc_datapath #(
    .OPC_W(OPC_W), .DISP_W(DISP_W), .LOW_W(LOW_W),
    .COND_OPC(COND_OPC), .UNCOND_OPC(UNCOND_OPC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decWord(decWord),
    .strobe(strobe), .sbbSeen(sbbSeen), .cntZero(cntZero)
  );

  lc_control u_ctl (
    .clk(clk), .rstN(rstN), .sbbSeen(sbbSeen), .cntZero(cntZero),
    .exSeq(exSeq), .exTaken(exTaken), .exCof(exCof),
    .strobe(strobe), .fillEn(fillEn), .useBuffer(useBuffer)
  );
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic clk,
  input logic rstN,
  input logic exTaken,
  input logic exCof,
  input logic fillEn,
  input logic useBuffer
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!fillEn && !useBuffer)); // R1

  AST_FILL_ENTRY_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !$past(fillEn)) |-> exTaken); // R3

  AST_BUFFER_ENTRY_FLOW: assert property (@(posedge clk) disable iff (!rstN)
    (useBuffer && !$past(useBuffer)) |-> (exTaken || exCof)); // R6

  AST_NO_ACTIVE_TO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    useBuffer |=> !fillEn); // R9

  AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(fillEn && useBuffer)); // R10
endmodule

bind loop_fetch_ctrl lc_checker u_chk (
  .clk(clk), .rstN(rstN), .exTaken(exTaken), .exCof(exCof),
  .fillEn(fillEn), .useBuffer(useBuffer)
);

// File: tb/tb_loop_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_loop_fetch_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        decValid;
  logic [15:0] decWord;
  logic        exSeq, exTaken, exCof;
  logic        fillEn, useBuffer;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk; // 200 MHz

  loop_fetch_ctrl dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decWord(decWord),
    .exSeq(exSeq), .exTaken(exTaken), .exCof(exCof),
    .fillEn(fillEn), .useBuffer(useBuffer)
  );

  // {req[3:0], dv, word[15:0], seq, taken, cof, expUse, expFill}
  function automatic logic [25:0] v(input int r, input bit dv, input logic [15:0] w,
                                    input bit s, input bit t, input bit c,
                                    input bit u, input bit f);
    v = {r[3:0], dv, w, s, t, c, u, f};
  endfunction

  localparam int NV = 42;
  localparam logic [25:0] VEC [NV] = '{
    // two-instruction loop, low field 110 (R2, R3, R5, R6, R7)
    v(2,1,16'hDFFE,0,0,0,0,0), v(3,0,16'h0,0,1,0,0,1),
    v(5,0,16'h0,1,0,0,0,1),    v(5,0,16'h0,1,0,0,0,1),
    v(6,0,16'h0,0,1,0,1,0),    v(5,0,16'h0,1,0,0,1,0),
    v(5,0,16'h0,1,0,0,1,0),    v(6,0,16'h0,0,1,0,1,0),
    v(5,0,16'h0,1,0,0,1,0),    v(5,0,16'h0,1,0,0,1,0),
    v(7,0,16'h0,1,0,0,0,0),    v(1,0,16'h0,0,0,0,0,0),
    // foreign change of flow in fill (R8), stray taken (R4)
    v(2,1,16'hDFFE,0,0,0,0,0), v(3,0,16'h0,0,1,0,0,1),
    v(8,0,16'h0,0,0,1,0,0),    v(4,0,16'h0,0,1,0,0,0),
    // upper field not all ones (R2)
    v(2,1,16'hD7FE,0,0,0,0,0), v(2,0,16'h0,0,1,0,0,0),
    // candidate not taken (R4)
    v(2,1,16'hDFFE,0,0,0,0,0), v(4,0,16'h0,1,0,0,0,0),
    v(4,0,16'h0,0,1,0,0,0),
    // unconditional, low field 000 => eight instructions (R5, R6, R8)
    v(2,1,16'hEFF8,0,0,0,0,0), v(3,0,16'h0,0,1,0,0,1),
    v(5,0,16'h0,1,0,0,0,1),    v(5,0,16'h0,1,0,0,0,1),
    v(5,0,16'h0,1,0,0,0,1),    v(5,0,16'h0,1,0,0,0,1),
    v(5,0,16'h0,1,0,0,0,1),    v(5,0,16'h0,1,0,0,0,1),
    v(5,0,16'h0,1,0,0,0,1),    v(5,0,16'h0,1,0,0,0,1),
    v(6,0,16'h0,0,0,1,1,0),    v(8,0,16'h0,0,0,1,0,0),
    // one-instruction loop; decode in active ignored (R9)
    v(2,1,16'hDFFF,0,0,0,0,0), v(3,0,16'h0,0,1,0,0,1),
    v(5,0,16'h0,1,0,0,0,1),    v(6,0,16'h0,0,1,0,1,0),
    v(9,1,16'hDFFE,1,0,0,1,0), v(9,0,16'h0,0,1,0,1,0),
    v(9,0,16'h0,1,0,0,1,0),    v(9,0,16'h0,0,1,0,1,0),
    v(8,0,16'h0,0,0,1,0,0)
  };

  task automatic check(input int req, input bit expUse, input bit expFill);
    checks++;
    if (useBuffer !== expUse || fillEn !== expFill) begin
      errors++;
      $display("FAIL R%0d: useBuffer=%b fillEn=%b expected useBuffer=%b fillEn=%b",
               req, useBuffer, fillEn, expUse, expFill);
    end
    // mutual exclusion, R10
    checks++;
    if (useBuffer && fillEn) begin
      errors++;
      $display("FAIL R10: useBuffer=%b fillEn=%b expected not both high", useBuffer, fillEn);
    end
  endtask

  task automatic drive(input bit dv, input logic [15:0] w, input bit s,
                       input bit t, input bit c);
    @(negedge clk);
    decValid = dv; decWord = w; exSeq = s; exTaken = t; exCof = c;
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; decValid = 1'b0; decWord = '0;
    exSeq = 1'b0; exTaken = 1'b0; exCof = 1'b0;
    // R1: outputs quiet while reset held, even with a sbb and taken presented
    drive(1, 16'hDFFE, 0, 1, 0);
    check(1, 0, 0);
    drive(0, 16'h0, 0, 0, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19:4], VEC[i][4+0] ? 1'b0 : 1'b0, 1'b0, 1'b0);
      decWord  = VEC[i][20:5];
      decValid = VEC[i][21];
      exSeq    = VEC[i][4];
      exTaken  = VEC[i][3];
      exCof    = VEC[i][2];
      #0.5;
      check(int'(VEC[i][25:22]), VEC[i][1], VEC[i][0]);
    end

    // R1: reset in the middle of an active loop
    drive(1, 16'hDFFF, 0, 0, 0); check(2, 0, 0);
    drive(0, 16'h0, 0, 1, 0);    check(3, 0, 1);
    drive(0, 16'h0, 1, 0, 0);    check(5, 0, 1);
    drive(0, 16'h0, 0, 1, 0);    check(6, 1, 0);
    drive(0, 16'h0, 0, 0, 0);
    rstN = 1'b0;
    #1;
    check(1, 0, 0);
    drive(0, 16'h0, 0, 0, 0);
    rstN = 1'b1;
    // after reset nothing is armed or active: R1, R4
    drive(0, 16'h0, 1, 0, 0); check(1, 0, 0);
    drive(0, 16'h0, 0, 1, 0); check(4, 0, 0);
    drive(0, 16'h0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule